// File: doc/BRIEF.md
# SDRAM Mode Register and Read-Burst Column Sequencer

This block is the device-side model of a double-data-rate SDRAM's base mode register and of the column sequencer that serves a read burst. A LOAD MODE command carries a bank-address pair and an address-bus word. When the bank address is zero, the word is decoded into burst length, burst type, read latency and operating mode. Any other bank address targets the extended register, and this block leaves it alone. Words that carry reserved codes are refused, and a sticky error flag records the refusal.

A READ command carries a starting column on the same address bus. The block latches the mode settings in force at that edge and steps through the burst one column per clock, in sequential or interleaved order. The columns are presented together with a data-valid strobe once the programmed latency has elapsed. A READ that arrives while a burst is running cuts that burst short and starts a new one.

Top module: `sdram_mode_seq`

## Requirements
- R1: Commands are sampled only on the rising clock edge, and register fields show the new value after that edge. Reset gives burst length 2, sequential type, latency 2, the error flag low, and no data-valid.
- R2: Address bits 2..0 of a base load set the burst length: 001 gives 2, 010 gives 4 and 011 gives 8. It is reported on `burstLen` as the value 2, 4 or 8.
- R3: Address bit 3 of a base load sets the burst type: 0 is sequential and 1 is interleaved. It is reported on `interleaved`.
- R4: Address bits 6..4 hold the read latency, and code 010 means 2 clocks. A READ registered at edge n gives no data-valid after edge n+1. It raises `dataValid` with the first column after edge n+2 and holds it for exactly burst-length consecutive cycles.
- R5: In sequential mode, the low log2(BL) column bits count up modulo BL from the start column.
- R6: In interleaved mode, the low log2(BL) column bits are the start column XOR a beat counter running 0..BL-1. In both modes the column bits above the low log2(BL) bits equal the start column.
- R7: A load whose bank address is not zero changes no reported field and does not set the error flag.
- R8: An operating-mode field (address bits 12..7) of zero is normal operation. A field with only address bit 8 set loads the register and pulses `dllResetPulse` for one cycle after the edge.
- R9: A base load with a reserved burst-length, latency or operating-mode code leaves every field unchanged. It also sets `modeErr`, which stays high until reset.
- R10: A READ registered while a burst is running truncates it. The old columns already due are still delivered, and the new burst's first column follows directly on the cycle its latency dictates.
- R11: When LOAD and READ are sampled on the same edge, the burst uses the settings in force before that edge, and the new settings apply afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdLoad | input | 1 | LOAD MODE command |
| cmdRead | input | 1 | READ command |
| ba | input | BA_W | Bank address; zero selects the base register |
| addr | input | ADDR_W | Address bus: mode word on load, start column on read |
| burstLen | output | 4 | Current burst length (2, 4 or 8) |
| interleaved | output | 1 | Current burst type, 1 = interleaved |
| casLat | output | 3 | Current read latency in clocks |
| modeErr | output | 1 | Sticky flag for a refused reserved code |
| dllResetPulse | output | 1 | One-cycle pulse after a load requesting DLL reset |
| dataValid | output | 1 | Column on colOut is a valid burst beat |
| colOut | output | COL_W | Column of the current beat |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a mode load and a read: the bench asserts both commands on one edge with a word that would change length and type. It then judges the burst against the old settings while the reported fields already show the new ones. The second pair is a running burst and a fresh read: a second READ lands two edges after the first in an 8-beat burst. The bench expects exactly two old columns followed seamlessly by the full new sequence, then data-valid dropping.

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  // Settings held by the base mode register
  typedef struct packed {
    logic [1:0] blLog;       // log2 of burst length (1..3)
    logic       interleave;  // 1 = interleaved order
    logic [2:0] casLat;      // read latency in clocks
  } modeCfg_t;

  // Strobes from control to the column datapath
  typedef struct packed {
    logic       startBurst;  // capture start column this edge
    logic       beatValid;   // a beat is being issued
    logic [2:0] beatIdx;     // beat number within burst
    logic [1:0] blLog;       // burst length of running burst
    logic       interleave;  // order of running burst
    logic [2:0] latSel;      // latency of running burst
  } seqStrobe_t;

  localparam logic [2:0] CL_CODE_TWO = 3'b010;
  localparam logic [2:0] CL_VALUE_TWO = 3'd2;

endpackage

// File: rtl/sdram_mode_ctrl.sv
module sdram_mode_ctrl
  import sdram_mode_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic              cmdRead,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output modeCfg_t          cfg,
  output logic              modeErr,
  output logic              dllResetPulse,
  output seqStrobe_t        strb
);

  localparam int OP_LSB = 7;
  localparam int OP_W   = ADDR_W - OP_LSB;

  // ---------------- field decode ----------------
  logic [2:0]      blCode;
  logic [2:0]      clCode;
  logic [OP_W-1:0] opField;
  logic            blOk, clOk, opNormal, opDll, opOk;
  logic            baseSel, goodLoad, badLoad;

  always_comb begin
    blCode   = addr[2:0];
    clCode   = addr[6:4];
    opField  = addr[ADDR_W-1:OP_LSB];
    blOk     = (blCode == 3'b001) || (blCode == 3'b010) || (blCode == 3'b011);
    clOk     = (clCode == CL_CODE_TWO);
    opNormal = (opField == '0);
    opDll    = (opField == OP_W'(2));
    opOk     = opNormal || opDll;
    baseSel  = cmdLoad && (ba == '0);
    goodLoad = baseSel && blOk && clOk && opOk;
    badLoad  = baseSel && !(blOk && clOk && opOk);
  end

  // ---------------- mode register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg           <= '{blLog: 2'd1, interleave: 1'b0, casLat: CL_VALUE_TWO};
      modeErr       <= 1'b0;
      dllResetPulse <= 1'b0;
    end else begin
      dllResetPulse <= goodLoad && opDll;
      if (goodLoad) begin
        cfg.blLog      <= blCode[1:0];
        cfg.interleave <= addr[3];
        cfg.casLat     <= CL_VALUE_TWO;
      end
      if (badLoad) modeErr <= 1'b1;
    end
  end

  // ---------------- burst counter ----------------
  logic       active;
  logic [2:0] beatCnt;
  logic [1:0] burstBl;
  logic       burstIl;
  logic [2:0] burstLat;
  logic [2:0] lastIdx;

  always_comb lastIdx = 3'((4'd1 << burstBl) - 4'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      beatCnt  <= '0;
      burstBl  <= 2'd1;
      burstIl  <= 1'b0;
      burstLat <= CL_VALUE_TWO;
    end else if (cmdRead) begin
      // settings before this edge govern the new burst
      active   <= 1'b1;
      beatCnt  <= '0;
      burstBl  <= cfg.blLog;
      burstIl  <= cfg.interleave;
      burstLat <= cfg.casLat;
    end else if (active) begin
      if (beatCnt == lastIdx) active <= 1'b0;
      beatCnt <= beatCnt + 3'd1;
    end
  end

  always_comb begin
    strb.startBurst = cmdRead;
    strb.beatValid  = active;
    strb.beatIdx    = beatCnt;
    strb.blLog      = burstBl;
    strb.interleave = burstIl;
    strb.latSel     = burstLat;
  end

  // ---------------- assertions ----------------
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);  // R9
  AST_BAD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    badLoad |=> $stable(cfg));  // R9
  AST_EXT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLoad && ba != '0 && !modeErr) |=> ($stable(cfg) && !modeErr));  // R7
  AST_DLL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    dllResetPulse |-> ($past(cmdLoad) && $past(addr[8])));  // R8
  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (beatCnt <= lastIdx));  // R2

endmodule

// File: rtl/sdram_burst_dpath.sv
module sdram_burst_dpath
  import sdram_mode_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int MAX_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [COL_W-1:0] colIn,
  output logic             dataValid,
  output logic [COL_W-1:0] colOut
);

  // ---------------- start column ----------------
  logic [COL_W-1:0] startCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               startCol <= '0;
    else if (strb.startBurst) startCol <= colIn;
  end

  // ---------------- column ordering ----------------
  logic [2:0]       lowMask, lowStart, seqLow, ilLow, pickLow;
  logic [COL_W-1:0] colNow;

  always_comb begin
    lowMask  = 3'((4'd1 << strb.blLog) - 4'd1);
    lowStart = startCol[2:0];
    seqLow   = lowStart + strb.beatIdx;
    ilLow    = lowStart ^ strb.beatIdx;
    pickLow  = strb.interleave ? ilLow : seqLow;
    colNow   = {startCol[COL_W-1:3], (lowStart & ~lowMask) | (pickLow & lowMask)};
  end

  // ---------------- latency pipeline ----------------
  logic [MAX_LAT-1:0] pipeV;
  logic [COL_W-1:0]   pipeC [MAX_LAT];

  generate
    for (genvar s = 0; s < MAX_LAT; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipeV[s] <= 1'b0;
          pipeC[s] <= '0;
        end else if (s == 0) begin
          pipeV[s] <= strb.beatValid;
          pipeC[s] <= colNow;
        end else begin
          pipeV[s] <= pipeV[(s == 0) ? 0 : s-1];
          pipeC[s] <= pipeC[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    dataValid = 1'b0;
    colOut    = '0;
    for (int i = 0; i < MAX_LAT; i++) begin
      if (3'(i + 1) == strb.latSel) begin
        dataValid = pipeV[i];
        colOut    = pipeC[i];
      end
    end
  end

  // ---------------- assertions ----------------
  AST_COL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatValid |-> ((colNow >> strb.blLog) == (startCol >> strb.blLog)));  // R6
  AST_LAT_TWO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latSel == 3'd2) |-> (dataValid == $past(strb.beatValid, 2)));  // R4

endmodule

// File: rtl/sdram_mode_seq.sv
module sdram_mode_seq
  import sdram_mode_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int COL_W   = 10,
  parameter int MAX_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic              cmdRead,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        burstLen,
  output logic              interleaved,
  output logic [2:0]        casLat,
  output logic              modeErr,
  output logic              dllResetPulse,
  output logic              dataValid,
  output logic [COL_W-1:0]  colOut
);

  modeCfg_t   cfg;
  seqStrobe_t strb;

  sdram_mode_ctrl #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdLoad      (cmdLoad),
    .cmdRead      (cmdRead),
    .ba           (ba),
    .addr         (addr),
    .cfg          (cfg),
    .modeErr      (modeErr),
    .dllResetPulse(dllResetPulse),
    .strb         (strb)
  );

  sdram_burst_dpath #(.COL_W(COL_W), .MAX_LAT(MAX_LAT)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .colIn    (addr[COL_W-1:0]),
    .dataValid(dataValid),
    .colOut   (colOut)
  );

  always_comb begin
    burstLen    = 4'(4'd1 << cfg.blLog);
    interleaved = cfg.interleave;
    casLat      = cfg.casLat;
  end

endmodule

// File: tb/sim_sdram_mode_seq.sv
module sim_sdram_mode_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdLoad = 1'b0;
  logic        cmdRead = 1'b0;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [3:0]  burstLen;
  logic        interleaved;
  logic [2:0]  casLat;
  logic        modeErr;
  logic        dllResetPulse;
  logic        dataValid;
  logic [9:0]  colOut;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  sdram_mode_seq u0 (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdRead(cmdRead), .ba(ba),
    .addr(addr), .burstLen(burstLen), .interleaved(interleaved), .casLat(casLat),
    .modeErr(modeErr), .dllResetPulse(dllResetPulse), .dataValid(dataValid),
    .colOut(colOut)
  );

  typedef struct packed {
    logic [12:0]      mode;
    logic [9:0]       col;
    logic [3:0]       len;
    logic [0:7][9:0]  seqExp;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{13'h022, 10'h105, 4'd4, {10'h105, 10'h106, 10'h107, 10'h104, 40'h0}},
    '{13'h02A, 10'h105, 4'd4, {10'h105, 10'h104, 10'h107, 10'h106, 40'h0}},
    '{13'h023, 10'h2FE, 4'd8, {10'h2FE, 10'h2FF, 10'h2F8, 10'h2F9,
                               10'h2FA, 10'h2FB, 10'h2FC, 10'h2FD}},
    '{13'h02B, 10'h2FE, 4'd8, {10'h2FE, 10'h2FF, 10'h2FC, 10'h2FD,
                               10'h2FA, 10'h2FB, 10'h2F8, 10'h2F9}},
    '{13'h021, 10'h3FF, 4'd2, {10'h3FF, 10'h3FE, 60'h0}},
    '{13'h029, 10'h000, 4'd2, {10'h000, 10'h001, 60'h0}},
    '{13'h022, 10'h0A6, 4'd4, {10'h0A6, 10'h0A7, 10'h0A4, 10'h0A5, 40'h0}}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // drive at a falling edge, release at the next; returns just after the rising edge
  task automatic doLoad(input logic [1:0] b, input logic [12:0] w);
    cmdLoad = 1'b1; ba = b; addr = w;
    @(negedge clk);
    cmdLoad = 1'b0; ba = '0;
  endtask

  task automatic runRead(input logic [9:0] col, input int len,
                         input logic [0:7][9:0] seqExp, input string req);
    cmdRead = 1'b1; addr = 13'(col);
    @(negedge clk);                       // after edge n
    cmdRead = 1'b0;
    @(negedge clk);                       // after edge n+1
    check(!dataValid, "R4 early", 32'(dataValid), 0);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);                     // after edge n+2+k
      check(dataValid, req, 32'(dataValid), 1);
      check(colOut == seqExp[k], req, 32'(colOut), 32'(seqExp[k]));
    end
    @(negedge clk);
    check(!dataValid, "R4 length", 32'(dataValid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(burstLen == 4'd2, "R1 reset BL", 32'(burstLen), 2);
    check(!interleaved, "R1 reset type", 32'(interleaved), 0);
    check(casLat == 3'd2, "R1 reset CL", 32'(casLat), 2);
    check(!modeErr, "R1 reset err", 32'(modeErr), 0);
    check(!dataValid && !dllResetPulse, "R1 reset strobes", 32'({dataValid, dllResetPulse}), 0);

    // vector table: R2 R3 R5 R6 R4
    for (int v = 0; v < 7; v++) begin
      doLoad(2'b00, VECS[v].mode);
      check(burstLen == VECS[v].len, "R2 length", 32'(burstLen), 32'(VECS[v].len));
      check(interleaved == VECS[v].mode[3], "R3 type", 32'(interleaved), 32'(VECS[v].mode[3]));
      runRead(VECS[v].col, int'(VECS[v].len), VECS[v].seqExp,
              VECS[v].mode[3] ? "R6 order" : "R5 order");
    end

    // R8 DLL reset pulse
    doLoad(2'b00, 13'h122);
    check(dllResetPulse, "R8 pulse", 32'(dllResetPulse), 1);
    check(burstLen == 4'd4, "R8 loaded", 32'(burstLen), 4);
    @(negedge clk);
    check(!dllResetPulse, "R8 one cycle", 32'(dllResetPulse), 0);
    doLoad(2'b00, 13'h022);
    check(!dllResetPulse, "R8 normal no pulse", 32'(dllResetPulse), 0);

    // R11 load and read on the same edge: burst uses BL4 sequential
    cmdLoad = 1'b1; cmdRead = 1'b1; addr = 13'h02B;
    @(negedge clk);
    cmdLoad = 1'b0; cmdRead = 1'b0;
    check(burstLen == 4'd8 && interleaved, "R11 new cfg", 32'({burstLen, interleaved}), 32'h11);
    @(negedge clk);
    check(!dataValid, "R11 early", 32'(dataValid), 0);
    for (int k = 0; k < 4; k++) begin
      logic [9:0] e;
      e = {8'h0A, 2'(3 + k)};
      @(negedge clk);
      check(dataValid && colOut == e, "R11 old burst", 32'(colOut), 32'(e));
    end
    @(negedge clk);
    check(!dataValid, "R11 length", 32'(dataValid), 0);

    // R10 truncation: BL8 sequential, second READ two edges later
    doLoad(2'b00, 13'h023);
    cmdRead = 1'b1; addr = 13'h000;
    @(negedge clk);
    cmdRead = 1'b0;
    @(negedge clk);
    cmdRead = 1'b1; addr = 13'h105;
    @(negedge clk);
    cmdRead = 1'b0;
    for (int k = 0; k < 10; k++) begin
      logic [9:0] e;
      if (k < 2) e = 10'(k);
      else       e = {7'b0100000, 3'(5 + k - 2)};
      check(dataValid && colOut == e, "R10 truncate", 32'(colOut), 32'(e));
      @(negedge clk);
    end
    check(!dataValid, "R10 end", 32'(dataValid), 0);

    // R7 extended register ignored (before any error)
    doLoad(2'b10, 13'h000);
    check(!modeErr && burstLen == 4'd8, "R7 ext ignored", 32'({modeErr, burstLen}), 8);
    doLoad(2'b01, 13'h029);
    check(burstLen == 4'd8 && !interleaved, "R7 ext no change", 32'({burstLen, interleaved}), 32'h10);

    // R9 reserved codes
    doLoad(2'b00, 13'h022);
    doLoad(2'b00, 13'h024);
    check(modeErr, "R9 bad BL err", 32'(modeErr), 1);
    check(burstLen == 4'd4, "R9 bad BL kept", 32'(burstLen), 4);
    doLoad(2'b00, 13'h03B);
    check(burstLen == 4'd4 && !interleaved && casLat == 3'd2, "R9 bad CL kept",
          32'({burstLen, interleaved, casLat}), 32'h42);
    doLoad(2'b00, 13'h0AB);
    check(burstLen == 4'd4 && !interleaved, "R9 bad op kept", 32'({burstLen, interleaved}), 32'h40 >> 3);
    check(!dllResetPulse, "R9 bad op no pulse", 32'(dllResetPulse), 0);
    doLoad(2'b00, 13'h021);
    check(burstLen == 4'd2, "R9 good after bad", 32'(burstLen), 2);
    check(modeErr, "R9 sticky", 32'(modeErr), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule